// File: doc/BRIEF.md
# Wake-up Exit Delay Controller

This block decides when a processor may restart instruction execution after it leaves sleep or an idle mode. When a wake event arrives, it captures two 3-bit codes: the clock source that was active while the core was halted, and the clock source selected for execution after wake-up. From that pair it picks the waits that apply:

- a fixed CPU-settling count;
- a crystal start-up count;
- a start-up count followed by a PLL lock count;
- an internal-oscillator stabilisation window, during which execution is already allowed.

The settling count always runs. It runs alongside the oscillator count, so execution restarts after the longer of the two, not after their sum.

The block drives three outputs: a one-cycle resume strobe, a primary-oscillator ready flag and an internal-oscillator ready flag. All intervals are parameters counted in system clock cycles. The oscillators themselves are not modelled; crystal and PLL readiness are timed only by counters.

All pins are plain control and status; no data stream passes through the block. Timing convention: a wake sampled at clock edge n with an exit delay of D cycles makes `resume` high for exactly the cycle that follows edge n+D. The `sleep_enter` pin marks the core going back to sleep and re-arms the block for the next wake.

Top module: `wake_exit_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `resume`, `pri_rdy` and `int_rdy` low and the block asleep, ready to accept a wake.
- R2: Before-wake codes: 0 = primary kept running, 1 = secondary oscillator, 2 = internal oscillator, 3 to 7 = all clocks stopped. After-wake codes: 0 = crystal, 1 = crystal with PLL, 2 = external clock or RC, 3 = internal oscillator, 4 to 7 = treated as external clock or RC.
- R3: With before code 0 and a crystal or PLL target, no start-up count is used. `resume` and `pri_rdy` both rise after T_CSD cycles.
- R4: With a crystal target (after code 0) and any before code other than 0, `pri_rdy` rises after T_OST cycles. `resume` comes after max(T_CSD, T_OST) cycles.
- R5: With a PLL target (after code 1) and any before code other than 0, the lock count starts the cycle after the start-up count ends. `pri_rdy` rises after T_OST+T_PLL cycles, and `resume` comes after max(T_CSD, T_OST+T_PLL) cycles.
- R6: With an external clock or RC target (after codes 2 or 4 to 7), `resume` comes after T_CSD cycles and `pri_rdy` stays low.
- R7: With an internal-oscillator target (after code 3) and before code 0, 1 or 3 to 7, `resume` comes after T_CSD cycles. `int_rdy` rises after T_IOB cycles, even when that is later than `resume`.
- R8: With an internal-oscillator target and before code 2, `int_rdy` is high from the cycle right after the wake edge, and `resume` comes after T_CSD cycles.
- R9: `resume` is high for exactly one cycle per accepted wake.
- R10: A wake, a code change or a `sleep_enter` during the delay has no effect on any output's timing. A wake while running is ignored.
- R11: `sleep_enter` high in the running state returns the block to asleep and clears both ready flags one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wake | input | 1 | Wake event, accepted only while asleep |
| sleep_enter | input | 1 | Core re-enters sleep; honoured only while running |
| src_before | input | 3 | Clock source active before wake (R2 coding) |
| src_after | input | 3 | Clock source selected after wake (R2 coding) |
| resume | output | 1 | One-cycle strobe: execution restarts |
| pri_rdy | output | 1 | Primary oscillator start-up complete |
| int_rdy | output | 1 | Internal oscillator stable |

## Verification
Every result is timed from the wake edge n: `resume` is due exactly D cycles later, `pri_rdy` at its own start-up or settling count, and `int_rdy` at 0 or T_IOB cycles. After each wake the bench samples all three outputs on the falling edge of every cycle over a window longer than the longest chain. Each output's expected level in each cycle comes from a bench function of the two codes, so the checks catch early, late, missing and repeated edges alike. The flag clearing after `sleep_enter` is due one cycle later and is sampled at that point.

// File: rtl/wx_pkg.sv
package wx_pkg;
  localparam int CODE_W = 3;

  // before-wake codes
  localparam logic [CODE_W-1:0] BF_PRIMARY  = 3'd0;
  localparam logic [CODE_W-1:0] BF_SECOND   = 3'd1;
  localparam logic [CODE_W-1:0] BF_INTERNAL = 3'd2;

  // after-wake codes
  localparam logic [CODE_W-1:0] AF_CRYSTAL  = 3'd0;
  localparam logic [CODE_W-1:0] AF_PLL      = 3'd1;
  localparam logic [CODE_W-1:0] AF_EXTCLK   = 3'd2;
  localparam logic [CODE_W-1:0] AF_INTERNAL = 3'd3;

  typedef enum logic [1:0] {ST_ASLEEP, ST_WAIT, ST_RUN} wx_state_t;

  typedef struct packed {
    logic ost;      // start-up count required
    logic pll;      // lock count follows start-up
    logic iob;      // internal stabilisation window required
    logic pri_tgt;  // target is a crystal mode
    logic int_tgt;  // target is internal oscillator
    logic int_now;  // internal oscillator already stable
  } wx_path_t;
endpackage

// File: rtl/wx_path_sel.sv
module wx_path_sel
  import wx_pkg::*;
(
  input  logic [CODE_W-1:0] src_before,
  input  logic [CODE_W-1:0] src_after,
  output wx_path_t          path
);
  logic crystal_like;
  logic prim_ran;
  logic int_ran;

  always_comb begin
    crystal_like = (src_after == AF_CRYSTAL) || (src_after == AF_PLL);
    prim_ran     = (src_before == BF_PRIMARY);
    int_ran      = (src_before == BF_INTERNAL);
    path.pri_tgt = crystal_like;
    path.ost     = crystal_like && !prim_ran;
    path.pll     = (src_after == AF_PLL) && !prim_ran;
    path.int_tgt = (src_after == AF_INTERNAL);
    path.iob     = (src_after == AF_INTERNAL) && !int_ran;
    path.int_now = (src_after == AF_INTERNAL) && int_ran;
  end
endmodule

// File: rtl/wx_countdown.sv
module wx_countdown #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int W = (LEN < 2) ? 1 : $clog2(LEN + 1);

  logic [W-1:0] cnt;
  logic         busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= W'(LEN);
    end else if (busy) begin
      if (cnt == W'(1)) busy <= 1'b0;
      else              cnt  <= cnt - W'(1);
    end
  end

  assign fire = busy && (cnt == W'(1));

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && !fire) |=> (busy && cnt == $past(cnt) - W'(1))); // R4
  AST_FIRE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (fire && !start) |=> !busy); // R9
endmodule

// File: rtl/wx_osc_chain.sv
module wx_osc_chain #(
  parameter int T_OST = 40,
  parameter int T_PLL = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic use_pll,
  output logic osc_fire
);
  logic ost_fire;
  logic pll_fire;
  logic pll_start;

  assign pll_start = ost_fire && use_pll;

  wx_countdown #(.LEN(T_OST)) u_ost (
    .clk(clk), .rst(rst), .start(start), .fire(ost_fire)
  );

  wx_countdown #(.LEN(T_PLL)) u_pll (
    .clk(clk), .rst(rst), .start(pll_start), .fire(pll_fire)
  );

  assign osc_fire = use_pll ? pll_fire : ost_fire;

  AST_PLL_AFTER_OST: assert property (@(posedge clk) disable iff (rst)
    pll_start |-> !pll_fire); // R5
endmodule

// File: rtl/wake_exit_seq.sv
module wake_exit_seq
  import wx_pkg::*;
#(
  parameter int T_CSD = 4,
  parameter int T_OST = 40,
  parameter int T_PLL = 12,
  parameter int T_IOB = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake,
  input  logic              sleep_enter,
  input  logic [CODE_W-1:0] src_before,
  input  logic [CODE_W-1:0] src_after,
  output logic              resume,
  output logic              pri_rdy,
  output logic              int_rdy
);
  wx_state_t state;
  wx_path_t  path_in;
  logic      accept;
  logic      pll_q, pri_tgt_q, int_tgt_q;
  logic      csd_done, osc_done, int_pend;
  logic      csd_fire, osc_fire, iob_fire;
  logic      csd_nx, osc_nx;
  logic      go_sleep;

  wx_path_sel u_sel (
    .src_before(src_before), .src_after(src_after), .path(path_in)
  );

  assign accept   = wake && (state == ST_ASLEEP);
  assign go_sleep = sleep_enter && (state == ST_RUN);

  wx_countdown #(.LEN(T_CSD)) u_csd (
    .clk(clk), .rst(rst), .start(accept), .fire(csd_fire)
  );

  wx_osc_chain #(.T_OST(T_OST), .T_PLL(T_PLL)) u_osc (
    .clk(clk), .rst(rst), .start(accept && path_in.ost),
    .use_pll(accept ? path_in.pll : pll_q), .osc_fire(osc_fire)
  );

  wx_countdown #(.LEN(T_IOB)) u_iob (
    .clk(clk), .rst(rst), .start(accept && path_in.iob), .fire(iob_fire)
  );

  assign csd_nx = csd_done || csd_fire;
  assign osc_nx = osc_done || osc_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ASLEEP;
      resume    <= 1'b0;
      pri_rdy   <= 1'b0;
      int_rdy   <= 1'b0;
      pll_q     <= 1'b0;
      pri_tgt_q <= 1'b0;
      int_tgt_q <= 1'b0;
      csd_done  <= 1'b0;
      osc_done  <= 1'b0;
      int_pend  <= 1'b0;
    end else begin
      resume <= 1'b0;
      if (int_pend && iob_fire) begin
        int_rdy  <= 1'b1;
        int_pend <= 1'b0;
      end
      unique case (state)
        ST_ASLEEP: begin
          if (wake) begin
            pll_q     <= path_in.pll;
            pri_tgt_q <= path_in.pri_tgt;
            int_tgt_q <= path_in.int_tgt;
            csd_done  <= 1'b0;
            osc_done  <= !path_in.ost;
            int_pend  <= path_in.iob;
            if (path_in.int_now) int_rdy <= 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          csd_done <= csd_nx;
          osc_done <= osc_nx;
          if (osc_fire && pri_tgt_q) pri_rdy <= 1'b1;
          if (csd_nx && osc_nx) begin
            resume <= 1'b1;
            if (pri_tgt_q) pri_rdy <= 1'b1;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (sleep_enter) begin
            state    <= ST_ASLEEP;
            pri_rdy  <= 1'b0;
            int_rdy  <= 1'b0;
            int_pend <= 1'b0;
          end
        end
        default: state <= ST_ASLEEP;
      endcase
    end
  end

  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume); // R9
  AST_RESUME_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    resume |-> (state == ST_RUN)); // R9
  AST_CHOICE_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_ASLEEP) |=> ($stable(pll_q) && $stable(pri_tgt_q) && $stable(int_tgt_q))); // R10
  AST_PRI_CRYSTAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    pri_rdy |-> pri_tgt_q); // R6
  AST_INT_TARGET_ONLY: assert property (@(posedge clk) disable iff (rst)
    int_rdy |-> int_tgt_q); // R7
  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    go_sleep |=> (!pri_rdy && !int_rdy && !resume)); // R11
endmodule

// File: tb/sim_wake_exit_seq.sv
module sim_wake_exit_seq;
  localparam int T_CSD = 4;
  localparam int T_OST = 40;
  localparam int T_PLL = 12;
  localparam int T_IOB = 24;
  localparam int HOR   = T_OST + T_PLL + T_IOB + 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wake = 1'b0;
  logic       sleep_enter = 1'b0;
  logic [2:0] src_before = '0;
  logic [2:0] src_after = '0;
  logic       resume, pri_rdy, int_rdy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wake_exit_seq #(.T_CSD(T_CSD), .T_OST(T_OST), .T_PLL(T_PLL), .T_IOB(T_IOB)) u0 (
    .clk(clk), .rst(rst), .wake(wake), .sleep_enter(sleep_enter),
    .src_before(src_before), .src_after(src_after),
    .resume(resume), .pri_rdy(pri_rdy), .int_rdy(int_rdy)
  );

  function automatic int osc_len(input logic [2:0] b, input logic [2:0] a);
    if (b == 3'd0) return 0;
    if (a == 3'd1) return T_OST + T_PLL;
    if (a == 3'd0) return T_OST;
    return 0;
  endfunction

  function automatic int exp_res(input logic [2:0] b, input logic [2:0] a);
    int o = osc_len(b, a);
    return (o > T_CSD) ? o : T_CSD;
  endfunction

  function automatic int exp_pri(input logic [2:0] b, input logic [2:0] a);
    if (a != 3'd0 && a != 3'd1) return -1;
    return (b == 3'd0) ? T_CSD : osc_len(b, a);
  endfunction

  function automatic int exp_int(input logic [2:0] b, input logic [2:0] a);
    if (a != 3'd3) return -1;
    return (b == 3'd2) ? 0 : T_IOB;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] b, input logic [2:0] a);
    if (a == 3'd3) return (b == 3'd2) ? "R8" : "R7";
    if (a == 3'd0 || a == 3'd1) return (b == 3'd0) ? "R3" : ((a == 3'd1) ? "R5" : "R4");
    return "R6";
  endfunction

  // one wake, full window check, then back to sleep
  task automatic run_case(input logic [2:0] b, input logic [2:0] a, input bit glitch);
    int r = exp_res(b, a);
    int p = exp_pri(b, a);
    int i = exp_int(b, a);
    int bad_r = -1, bad_p = -1, bad_i = -1;
    int nres = 0;
    string rq = req_of(b, a);
    @(negedge clk);
    src_before = b; src_after = a; wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    for (int k = 0; k <= HOR; k++) begin
      if (resume) nres++;
      if (bad_r < 0 && resume != (k == r)) bad_r = k;
      if (bad_p < 0 && pri_rdy != (p >= 0 && k >= p)) bad_p = k;
      if (bad_i < 0 && int_rdy != (i >= 0 && k >= i)) bad_i = k;
      if (glitch && k == 2) begin
        wake = 1'b1; sleep_enter = 1'b1;
        src_before = 3'($urandom_range(0, 7)); src_after = 3'($urandom_range(0, 7));
      end else if (glitch && k == 3) begin
        wake = 1'b0; sleep_enter = 1'b0;
      end
      @(negedge clk);
    end
    check(bad_r < 0, {rq, glitch ? "/R10 resume timing" : " resume timing"}, bad_r, r);
    check(bad_p < 0, {rq, glitch ? "/R10 pri_rdy timing" : " pri_rdy timing"}, bad_p, p);
    check(bad_i < 0, {rq, glitch ? "/R10 int_rdy timing" : " int_rdy timing"}, bad_i, i);
    check(nres == 1, "R9 single resume strobe", nres, 1);
    sleep_enter = 1'b1;
    @(negedge clk);
    sleep_enter = 1'b0;
    check(!pri_rdy && !int_rdy && !resume, "R11 flags cleared on sleep",
          {pri_rdy, int_rdy, resume}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int seen;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!resume && !pri_rdy && !int_rdy, "R1 reset state", {resume, pri_rdy, int_rdy}, 0);

    // directed: each before/after pairing of interest (R2 codes)
    run_case(3'd0, 3'd0, 1'b0); // R3
    run_case(3'd0, 3'd1, 1'b0); // R3
    run_case(3'd1, 3'd0, 1'b0); // R4
    run_case(3'd7, 3'd1, 1'b0); // R5
    run_case(3'd2, 3'd2, 1'b0); // R6
    run_case(3'd3, 3'd6, 1'b0); // R6, R2 alias code
    run_case(3'd1, 3'd3, 1'b0); // R7
    run_case(3'd2, 3'd3, 1'b0); // R8
    run_case(3'd5, 3'd1, 1'b1); // R10

    // R10: wake while running is ignored
    @(negedge clk);
    src_before = 3'd3; src_after = 3'd2; wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    repeat (T_CSD + 2) @(negedge clk);
    src_before = 3'd1; src_after = 3'd0; wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    seen = 0;
    for (int k = 0; k < HOR; k++) begin
      if (resume || pri_rdy) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R10 wake in run ignored", seen, 0);
    sleep_enter = 1'b1; @(negedge clk); sleep_enter = 1'b0;

    // reset mid-delay
    @(negedge clk);
    src_before = 3'd2; src_after = 3'd3; wake = 1'b1;
    @(negedge clk); wake = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!resume && !pri_rdy && !int_rdy, "R1 reset during wait", {resume, pri_rdy, int_rdy}, 0);

    for (int n = 0; n < 40; n++)
      run_case(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule